// File: doc/BRIEF.md
# Multicycle Phase Detector with Range Clamp

This block turns a stream of fractional phase samples, one per reference clock edge, into a signed phase-error word. Each sample gives the phase of the feedback clock against the reference as a fraction of one cycle. The block watches how that fraction moves between samples. When it rolls over the top of the circle, a slip counter goes up by one whole unit interval (UI). When it rolls under the bottom, the counter goes down by one. In this way the block follows phase errors of many cycles, not just ±360°. The result is a whole-UI count joined to the fraction and is meant to feed a loop filter.

An 8-bit configuration register controls the block. One bit enables a programmable coarse limit, one enables multicycle tracking, and one lets the loop use the multicycle measurement. A 4-bit code sets the limit as a power of two minus one, in UI. When the count would pass the selected limit, the block holds it at the edge of the range, reports a saturated error word and raises a limit flag. In one-cycle mode the error is confined to a single cycle each side, which gives gentler pull-in. In multicycle mode large errors are reported in full up to the limit, which gives faster pull-in.

Top module: `mcyc_phase_det`

## Requirements
- R1: After reset the configuration reads 0x85 (limit enable set, multicycle enable clear, use-multicycle clear, code 5), the error word is zero, and the limit and misconfiguration flags are low.
- R2: A configuration write stores the written byte, except that bit 4 always reads 0. The field positions are: bit 7 limit enable, bit 6 multicycle enable, bit 5 use-multicycle, bits 3:0 limit code.
- R3: On each sampled edge (`ref_tick` high), take d = (new − previous) mod 256. A forward wrap (new < previous and d < 128) adds 1 UI to the slip count. A reverse wrap (new > previous and d ≥ 128) subtracts 1 UI. The first sample after reset never counts as a wrap. The error word is {14-bit signed whole count, 8-bit fraction} and appears one clock after the sample.
- R4: While `ref_tick` is low, the error word and the limit flag stay unchanged, and input fractions presented then are neither stored nor counted.
- R5: With multicycle in effect (bits 6 and 5 both set) and bit 7 set, a code n from 0 to 11 gives a limit L = 2^(n+1) − 1. The whole count is kept within [−L, L−1].
- R6: Codes 12 to 15 all give L = 8191.
- R7: When a wrap would push the count past the range, the count is held at the edge. The word reads {L−1, 0xFF} at the top or {−L, 0x00} at the bottom, and `limit_active` is high.
- R8: A held count is released by the first wrap in the opposite direction. The word then reads {edge count, current fraction} and `limit_active` falls.
- R9: With use-multicycle clear, L = 1 whatever the code or the limit enable.
- R10: With use-multicycle set but multicycle enable clear, the block behaves as in R9 and `misconfig` is high.
- R11: With multicycle in effect and limit enable clear, L = 8191 (the hardware maximum).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Configuration readback |
| ref_tick | input | 1 | Marks a reference edge; `frac_in` is sampled |
| frac_in | input | FRAC_W (8) | Feedback phase as a fraction of a cycle |
| phase_err | output | WHOLE_W+FRAC_W (22) | {signed whole UI, fraction} |
| limit_active | output | 1 | Count is held at the range edge |
| misconfig | output | 1 | Use-multicycle set without multicycle enable |

## Verification
If the slip count goes wrong by a single missed or doubled wrap, the whole field of `phase_err` is off by one UI on the very next sampled edge. That error then persists, so ramps that are compared every sample catch it at once. A wrong range decode first shows up at the clamp point: the word saturates one or more samples too early or too late, or `limit_active` rises at the wrong count. This is why every code is ramped past its edge. A stuck limit state shows at the first reverse wrap after saturation, when the fraction should reappear.

// File: rtl/mcpd_pkg.sv
package mcpd_pkg;

   localparam int CFG_W      = 8;
   localparam int CODE_W     = 4;
   localparam logic [CFG_W-1:0] CFG_RESET = 8'h85;
   localparam logic [CFG_W-1:0] CFG_MASK  = 8'hEF;

   typedef struct packed {
      logic              lim_en;
      logic              mc_en;
      logic              mc_use;
      logic              spare;
      logic [CODE_W-1:0] code;
   } mcpd_cfg_t;

endpackage

// File: rtl/mcpd_cfg_reg.sv
module mcpd_cfg_reg
   import mcpd_pkg::*;
#(
   parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] q,
   output mcpd_cfg_t        cfg
);

   logic [CFG_W-1:0] reg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  reg_q <= RESET_VAL & CFG_MASK;
      else if (we) reg_q <= wdata & CFG_MASK;
   end

   assign q   = reg_q;
   assign cfg = mcpd_cfg_t'(reg_q);

endmodule

// File: rtl/mcpd_range_sel.sv
module mcpd_range_sel
   import mcpd_pkg::*;
#(
   parameter int WHOLE_W = 14
) (
   input  mcpd_cfg_t                  cfg,
   output logic signed [WHOLE_W-1:0]  hi,
   output logic signed [WHOLE_W-1:0]  lo,
   output logic                       misconfig
);

   localparam int N_CODES = 1 << CODE_W;
   localparam int MAX_EXP = WHOLE_W - 2;
   localparam logic [WHOLE_W-1:0] HW_MAX = (WHOLE_W)'((1 << (WHOLE_W - 1)) - 1);

   logic [WHOLE_W-1:0] lim_tab [N_CODES];

   for (genvar g = 0; g < N_CODES; g++) begin : g_tab
      localparam int EXP = (g < MAX_EXP) ? g : MAX_EXP;
      assign lim_tab[g] = (WHOLE_W)'((1 << (EXP + 1)) - 1);
   end

   logic               multi;
   logic [WHOLE_W-1:0] lim;

   always_comb begin
      multi = cfg.mc_use & cfg.mc_en;
      if (!multi)           lim = (WHOLE_W)'(1);
      else if (!cfg.lim_en) lim = HW_MAX;
      else                  lim = lim_tab[cfg.code];
      hi = $signed(lim - (WHOLE_W)'(1));
      lo = $signed((WHOLE_W)'(0) - lim);
   end

   assign misconfig = cfg.mc_use & ~cfg.mc_en;

endmodule

// File: rtl/mcpd_wrap_det.sv
module mcpd_wrap_det #(
   parameter int FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [FRAC_W-1:0] frac,
   output logic              fwd,
   output logic              rev
);

   logic [FRAC_W-1:0] prev_q;
   logic              valid_q;
   logic [FRAC_W-1:0] diff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= '0;
         valid_q <= 1'b0;
      end else if (tick) begin
         prev_q  <= frac;
         valid_q <= 1'b1;
      end
   end

   always_comb begin
      diff = frac - prev_q;
      fwd  = tick & valid_q & (frac < prev_q) & ~diff[FRAC_W-1];
      rev  = tick & valid_q & (frac > prev_q) &  diff[FRAC_W-1];
   end

endmodule

// File: rtl/mcpd_slip_ctr.sv
module mcpd_slip_ctr #(
   parameter int FRAC_W  = 8,
   parameter int WHOLE_W = 14
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick,
   input  logic                        fwd,
   input  logic                        rev,
   input  logic [FRAC_W-1:0]           frac,
   input  logic signed [WHOLE_W-1:0]   hi,
   input  logic signed [WHOLE_W-1:0]   lo,
   output logic [WHOLE_W+FRAC_W-1:0]   err,
   output logic                        lim_active
);

   localparam int EXT_W = WHOLE_W + 1;

   logic signed [WHOLE_W-1:0]       w_q, w_d;
   logic                            top_q, top_d, bot_q, bot_d;
   logic [WHOLE_W+FRAC_W-1:0]       err_q, err_d;
   logic signed [EXT_W-1:0]         cand, hi_x, lo_x;

   always_comb begin
      cand  = $signed({w_q[WHOLE_W-1], w_q})
            + $signed({{WHOLE_W{1'b0}}, fwd})
            - $signed({{WHOLE_W{1'b0}}, rev});
      hi_x  = $signed({hi[WHOLE_W-1], hi});
      lo_x  = $signed({lo[WHOLE_W-1], lo});
      w_d   = w_q;
      top_d = top_q;
      bot_d = bot_q;
      if (top_q) begin
         w_d   = hi;
         top_d = ~rev;
      end else if (bot_q) begin
         w_d   = lo;
         bot_d = ~fwd;
      end else if (cand > hi_x) begin
         w_d   = hi;
         top_d = 1'b1;
      end else if (cand < lo_x) begin
         w_d   = lo;
         bot_d = 1'b1;
      end else begin
         w_d   = cand[WHOLE_W-1:0];
      end
      if (top_d)      err_d = {w_d, {FRAC_W{1'b1}}};
      else if (bot_d) err_d = {w_d, {FRAC_W{1'b0}}};
      else            err_d = {w_d, frac};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q   <= '0;
         top_q <= 1'b0;
         bot_q <= 1'b0;
         err_q <= '0;
      end else if (tick) begin
         w_q   <= w_d;
         top_q <= top_d;
         bot_q <= bot_d;
         err_q <= err_d;
      end
   end

   assign err        = err_q;
   assign lim_active = top_q | bot_q;

endmodule

// File: rtl/mcyc_phase_det.sv
module mcyc_phase_det
   import mcpd_pkg::*;
#(
   parameter int FRAC_W  = 8,
   parameter int WHOLE_W = 14,
   localparam int ERR_W  = WHOLE_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_q,
   input  logic              ref_tick,
   input  logic [FRAC_W-1:0] frac_in,
   output logic [ERR_W-1:0]  phase_err,
   output logic              limit_active,
   output logic              misconfig
);

   if (FRAC_W < 2 || FRAC_W > 16) begin : g_bad_frac
      $error("mcyc_phase_det: FRAC_W out of range");
   end
   if (WHOLE_W < 3 || WHOLE_W > 24) begin : g_bad_whole
      $error("mcyc_phase_det: WHOLE_W out of range");
   end

   mcpd_cfg_t                  cfg;
   logic signed [WHOLE_W-1:0]  hi, lo;
   logic                       fwd, rev;

   mcpd_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_q),
      .cfg   (cfg)
   );

   mcpd_range_sel #(.WHOLE_W(WHOLE_W)) u_range (
      .cfg       (cfg),
      .hi        (hi),
      .lo        (lo),
      .misconfig (misconfig)
   );

   mcpd_wrap_det #(.FRAC_W(FRAC_W)) u_wrap (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ref_tick),
      .frac  (frac_in),
      .fwd   (fwd),
      .rev   (rev)
   );

   mcpd_slip_ctr #(.FRAC_W(FRAC_W), .WHOLE_W(WHOLE_W)) u_slip (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (ref_tick),
      .fwd        (fwd),
      .rev        (rev),
      .frac       (frac_in),
      .hi         (hi),
      .lo         (lo),
      .err        (phase_err),
      .lim_active (limit_active)
   );

endmodule

// File: rtl/mcpd_checker.sv
module mcpd_checker #(
   parameter int FRAC_W  = 8,
   parameter int WHOLE_W = 14
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_we,
   input logic [7:0]                  cfg_wdata,
   input logic [7:0]                  cfg_q,
   input logic                        ref_tick,
   input logic [WHOLE_W+FRAC_W-1:0]   phase_err,
   input logic                        limit_active,
   input logic                        misconfig
);

   logic [WHOLE_W-1:0] whole;
   logic [FRAC_W-1:0]  fr;
   assign whole = phase_err[WHOLE_W+FRAC_W-1:FRAC_W];
   assign fr    = phase_err[FRAC_W-1:0];

   p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_q == ($past(cfg_wdata) & 8'hEF));

   p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(phase_err) && $stable(limit_active));

   p_clamp_frac_r7: assert property (@(posedge clk) disable iff (!rst_n)
      limit_active |-> (fr == '0 || fr == '1));

   p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && !(cfg_q[5] && cfg_q[6])) |=>
         (whole == '0 || whole == '1));

   p_misconfig_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[5] && !cfg_wdata[6]) |=> misconfig);

   p_hw_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
      whole != {1'b1, {(WHOLE_W-1){1'b0}}});

endmodule

bind mcyc_phase_det mcpd_checker #(.FRAC_W(FRAC_W), .WHOLE_W(WHOLE_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_wdata    (cfg_wdata),
   .cfg_q        (cfg_q),
   .ref_tick     (ref_tick),
   .phase_err    (phase_err),
   .limit_active (limit_active),
   .misconfig    (misconfig)
);

// File: tb/mcyc_phase_det_tb_top.sv
module mcyc_phase_det_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int FW = 8;
   localparam int WW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    cfg_q;
   logic          ref_tick = 1'b0;
   logic [FW-1:0] frac_in = '0;
   logic [WW+FW-1:0] phase_err;
   logic          limit_active;
   logic          misconfig;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcyc_phase_det dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .cfg_q        (cfg_q),
      .ref_tick     (ref_tick),
      .frac_in      (frac_in),
      .phase_err    (phase_err),
      .limit_active (limit_active),
      .misconfig    (misconfig)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      ref_tick = 1'b0;
      cfg_we   = 1'b0;
      rst_n    = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic tick(input logic [7:0] f);
      ref_tick = 1'b1; frac_in = f;
      @(posedge clk); @(negedge clk);
      ref_tick = 1'b0;
   endtask

   function automatic int lim_of(input logic [7:0] c);
      int n;
      if (!(c[5] && c[6])) return 1;
      if (!c[7]) return 8191;
      n = (c[3:0] > 12) ? 12 : int'(c[3:0]);
      return (1 << (n + 1)) - 1;
   endfunction

   function automatic longint word(input int w, input int f);
      return longint'({w[WW-1:0], f[FW-1:0]});
   endfunction

   // Linear ramp from reset; expected word computed from unwrapped phase.
   task automatic ramp(input string req, input logic [7:0] c, input int step, input int n);
      int lim, u, w, fr;
      longint ew;
      int bad;
      do_reset();
      write_cfg(c);
      lim = lim_of(c);
      bad = 0;
      for (int t = 0; t <= n; t++) begin
         u = step * t;
         tick(u[7:0]);
         w  = (u >= 0) ? u / 256 : -((-u + 255) / 256);
         fr = u - w * 256;
         if (w > lim - 1)   ew = word(lim - 1, 255);
         else if (w < -lim) ew = word(-lim, 0);
         else               ew = word(w, fr);
         if (phase_err != ew[WW+FW-1:0] ||
             limit_active != (w > lim - 1 || w < -lim)) begin
            bad++;
            if (bad < 4)
               $display("FAIL %s cfg=%h t=%0d actual=%h/%0b expected=%h/%0b", req, c, t,
                        phase_err, limit_active, ew[WW+FW-1:0], (w > lim - 1 || w < -lim));
         end
      end
      checks++;
      if (bad != 0) fails++;
   endtask

   initial begin
      int lim;
      do_reset();
      // R1 reset state
      chk("R1 cfg", cfg_q, 8'h85);
      chk("R1 err", phase_err, 0);
      chk("R1 lim", limit_active, 0);
      chk("R1 misconfig", misconfig, 0);

      // R2 write, spare bit reads 0; R10 flag
      write_cfg(8'hFF);
      chk("R2 readback", cfg_q, 8'hEF);
      chk("R10 flag off", misconfig, 0);
      write_cfg(8'h25);
      chk("R2 readback2", cfg_q, 8'h25);
      chk("R10 flag on", misconfig, 1);

      // R3 basic unwrap and R4 idle hold
      do_reset();
      write_cfg(8'hE5);
      tick(8'd200);
      chk("R3 first sample", phase_err, word(0, 200));
      tick(8'd40);
      chk("R3 fwd wrap", phase_err, word(1, 40));
      tick(8'd250);
      chk("R3 rev wrap", phase_err, word(0, 250));
      frac_in = 8'd10;  @(posedge clk); @(negedge clk);
      frac_in = 8'd130; @(posedge clk); @(negedge clk);
      chk("R4 idle hold", phase_err, word(0, 250));
      tick(8'd250);
      chk("R4 idle no wrap", phase_err, word(0, 250));

      // R7/R8 clamp and release at code 0
      do_reset();
      write_cfg(8'hE0);
      tick(8'd0); tick(8'd127); tick(8'd254); tick(8'd125);
      chk("R7 clamp word", phase_err, word(0, 255));
      chk("R7 clamp flag", limit_active, 1);
      tick(8'd200); tick(8'd70);
      chk("R7 held", phase_err, word(0, 255));
      tick(8'd200);
      chk("R8 release word", phase_err, word(0, 200));
      chk("R8 release flag", limit_active, 0);

      // R5/R6 sweep all codes upward, a few downward
      for (int code = 0; code < 16; code++) begin
         lim = lim_of(8'hE0 | 8'(code));
         ramp(code < 12 ? "R5 up" : "R6 up", 8'hE0 | 8'(code), 127, ((lim + 1) * 256) / 127 + 3);
      end
      for (int code = 0; code < 4; code++) begin
         lim = lim_of(8'hE0 | 8'(code));
         ramp("R5 down", 8'hE0 | 8'(code), -127, ((lim + 1) * 256) / 127 + 3);
      end
      ramp("R6 down", 8'hEE, -127, (8192 * 256) / 127 + 3);

      // R9 one-cycle, R10 misconfig fallback, R11 no limit enable
      ramp("R9 one-cycle up", 8'hCB, 127, 20);
      ramp("R9 one-cycle down", 8'h4B, -127, 20);
      ramp("R10 fallback", 8'hAB, 127, 20);
      chk("R10 flag in ramp", misconfig, 1);
      ramp("R11 hw max", 8'h63, 127, (8192 * 256) / 127 + 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule